// File: doc/BRIEF.md
# Cumulative Low-Time Alarm Timer

This block totals the time during which an active-low over-temperature alarm input is held asserted. It adds up every separate low period rather than timing a single pulse. Time is kept in a saturating counter that advances on a time-base clock-enable pulse. With the default 8-bit counter, one count is worth roughly 22.76 ms and the top bit is worth roughly 2.9 s. Bit 0 is forced to one as soon as an assertion begins, so even a brief alarm leaves a trace.

The running total is compared against a programmable limit of the same width. When the total is strictly greater than the limit, a sticky status flag sets. A registered, active-low, open-drain style interrupt output then pulls low unless a mask bit blocks it. A limit of zero therefore fires on the first assertion.

Software reads the total through a read strobe. The read returns the current value and clears it. If the alarm is still asserted at that moment, bit 0 is set again at once. A limit write loads the threshold. A control write sets the mask and can clear the status flag by writing one.

A two-state machine follows the alarm input. In state IDLE the input is high. The transition BEGIN (input low) moves it to state ACTIVE and produces the one-cycle start pulse. The transition END (input high) returns it to IDLE. While in ACTIVE, time-base pulses advance the counter.

Top module: `cum_alarm_timer`

## Requirements
- R1: After reset the count is 0, the status flag is 0, irq_n is 1, the limit is all ones and the mask is 0.
- R2: On the first cycle that alarm_n is low after being high, the count becomes count OR 1 on the next edge. A tick in that same cycle is ignored.
- R3: While alarm_n stays low, each cycle with tick_en high adds one to the count. The count saturates at all ones and never wraps.
- R4: While alarm_n is high, ticks leave the count unchanged. The count kept from earlier assertions is added to by later ones, starting with the OR-with-1 of R2.
- R5: In a cycle with rd_en high, rd_data shows the count before clearing. With alarm_n high, the count is 0 after that edge.
- R6: A read while alarm_n is low leaves the count at 1 after the edge. A read takes priority over ticks and starts.
- R7: The status flag sets on the edge after the registered count becomes strictly greater than the limit. A count equal to the limit does not set it, and a limit of 0 sets it after the first assertion.
- R8: The status flag stays set across reads of the count.
- R9: A control write with wr_data bit 1 set clears the status flag on that edge. If the count still exceeds the limit, the flag sets again on the following edge.
- R10: irq_n is low exactly when the status flag is set and the mask is 0, and it updates on the same edge as the flag and the mask. A control write stores wr_data bit 0 as the mask; a mask of 1 releases irq_n while the flag stays set.
- R11: A cycle with wr_limit_en high loads wr_data into the limit, which is used from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alarm_n | input | 1 | Synchronised active-low alarm input |
| tick_en | input | 1 | Time-base clock enable, one pulse per count |
| rd_en | input | 1 | Read strobe: returns the count and clears it |
| rd_data | output | CNT_W | Current accumulated count |
| wr_limit_en | input | 1 | Load the limit from wr_data |
| wr_ctrl_en | input | 1 | Control write: bit 0 mask, bit 1 clear status (write one to clear) |
| wr_data | input | CNT_W | Write data |
| lim_hit | output | 1 | Sticky limit-exceeded status flag |
| irq_n | output | 1 | Registered active-low interrupt |

## Verification
The bench builds the block with the default count width of 8. With that width, saturation at 255 is reached after a few hundred ticks, and the full range of the limit is exercised. Limits of 3, 0 and 255 are used. These cover the equal-versus-greater boundary, the first-assertion case and the case where saturation can never exceed the limit. The bench also runs reads during an assertion and while idle, and a status clear that is set again at once.

// File: rtl/cum_alarm_pkg.sv
package cum_alarm_pkg;
    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } trk_state_e;

    localparam int CTL_MASK_BIT = 0;
    localparam int CTL_CLR_BIT  = 1;
endpackage

// File: rtl/cat_fsm.sv
module cat_fsm
    import cum_alarm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       alarm_n,
    output trk_state_e state_q,
    output logic       live,
    output logic       start
);
    trk_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (!alarm_n) state_d = ST_ACTIVE;  // BEGIN
            ST_ACTIVE: if (alarm_n)  state_d = ST_IDLE;    // END
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        live  = !alarm_n;
        start = (state_q == ST_IDLE) && !alarm_n;
    end
endmodule

// File: rtl/cat_accum.sv
module cat_accum #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             live,
    input  logic             start,
    input  logic             tick_en,
    input  logic             rd_en,
    output logic [CNT_W-1:0] cnt_q
);
    localparam logic [CNT_W-1:0] MAXV = '1;
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (rd_en)
            cnt_d = live ? ONE : '0;
        else if (start)
            cnt_d = cnt_q | ONE;
        else if (live && tick_en && (cnt_q != MAXV))
            cnt_d = cnt_q + ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/cat_flag.sv
module cat_flag
    import cum_alarm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic             wr_limit_en,
    input  logic             wr_ctrl_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] lim_q,
    output logic             mask_q,
    output logic             flag_q,
    output logic             irq_n
);
    logic flag_d, mask_d, clr, over;

    always_comb begin
        over   = cnt_q > lim_q;
        clr    = wr_ctrl_en && wr_data[CTL_CLR_BIT];
        flag_d = clr ? 1'b0 : (flag_q || over);
        mask_d = wr_ctrl_en ? wr_data[CTL_MASK_BIT] : mask_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lim_q  <= '1;
            mask_q <= 1'b0;
            flag_q <= 1'b0;
            irq_n  <= 1'b1;
        end else begin
            if (wr_limit_en) lim_q <= wr_data;
            mask_q <= mask_d;
            flag_q <= flag_d;
            irq_n  <= !(flag_d && !mask_d);
        end
    end
endmodule

// File: rtl/cum_alarm_timer.sv
module cum_alarm_timer
    import cum_alarm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alarm_n,
    input  logic             tick_en,
    input  logic             rd_en,
    output logic [CNT_W-1:0] rd_data,
    input  logic             wr_limit_en,
    input  logic             wr_ctrl_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic             lim_hit,
    output logic             irq_n
);
    trk_state_e       state_q;
    logic             live, start, mask_q, flag_q;
    logic [CNT_W-1:0] cnt_q, lim_q;

    cat_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .alarm_n(alarm_n),
        .state_q(state_q), .live(live), .start(start)
    );

    cat_accum #(.CNT_W(CNT_W)) u_accum (
        .clk(clk), .rst_n(rst_n), .live(live), .start(start),
        .tick_en(tick_en), .rd_en(rd_en), .cnt_q(cnt_q)
    );

    cat_flag #(.CNT_W(CNT_W)) u_flag (
        .clk(clk), .rst_n(rst_n), .cnt_q(cnt_q),
        .wr_limit_en(wr_limit_en), .wr_ctrl_en(wr_ctrl_en), .wr_data(wr_data),
        .lim_q(lim_q), .mask_q(mask_q), .flag_q(flag_q), .irq_n(irq_n)
    );

    assign rd_data = cnt_q;
    assign lim_hit = flag_q;
endmodule

// File: rtl/cum_alarm_timer_chk.sv
module cum_alarm_timer_chk
    import cum_alarm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alarm_n,
    input logic             rd_en,
    input logic             wr_ctrl_en,
    input logic [CNT_W-1:0] wr_data,
    input trk_state_e       state_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] lim_q,
    input logic             mask_q,
    input logic             flag_q,
    input logic             irq_n
);
    localparam logic [CNT_W-1:0] MAXV = '1;
    logic clr_req;
    assign clr_req = wr_ctrl_en && wr_data[CTL_CLR_BIT];

    p_start_bit0_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !alarm_n && !rd_en) |=> cnt_q[0]);
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == MAXV && !rd_en) |=> (cnt_q == MAXV));
    p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_n && !rd_en) |=> $stable(cnt_q));
    p_read_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && alarm_n) |=> (cnt_q == '0));
    p_read_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !alarm_n) |=> (cnt_q == {{(CNT_W-1){1'b0}}, 1'b1}));
    p_exceed_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q > lim_q && !clr_req) |=> flag_q);
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_req) |=> flag_q);
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> !flag_q);
    p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (flag_q && !mask_q));
endmodule

bind cum_alarm_timer cum_alarm_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .alarm_n(alarm_n), .rd_en(rd_en),
    .wr_ctrl_en(wr_ctrl_en), .wr_data(wr_data), .state_q(state_q),
    .cnt_q(cnt_q), .lim_q(lim_q), .mask_q(mask_q), .flag_q(flag_q),
    .irq_n(irq_n)
);

// File: tb/cum_alarm_timer_tb_top.sv
`timescale 1ns/1ps
module cum_alarm_timer_tb_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         alarm_n = 1'b1, tick_en = 1'b0, rd_en = 1'b0;
    logic         wr_limit_en = 1'b0, wr_ctrl_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] rd_data;
    logic         lim_hit, irq_n;

    int  n_chk = 0, n_fail = 0;
    bit  done = 0;

    typedef struct { int sel; int exp; string tag; } exp_t;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    cum_alarm_timer #(.CNT_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .alarm_n(alarm_n), .tick_en(tick_en),
        .rd_en(rd_en), .rd_data(rd_data), .wr_limit_en(wr_limit_en),
        .wr_ctrl_en(wr_ctrl_en), .wr_data(wr_data), .lim_hit(lim_hit),
        .irq_n(irq_n)
    );

    // sel: 0 = count, 1 = status flag, 2 = irq_n
    task automatic push(input int sel, input int exp, input string tag);
        exp_t it;
        it.sel = sel; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic nxt();
        @(negedge clk);
    endtask

    // monitor: compares expectations once outputs have settled
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                exp_t it;
                int act;
                it = sb_q.pop_front();
                act = (it.sel == 0) ? int'(rd_data) : (it.sel == 1) ? int'(lim_hit) : int'(irq_n);
                n_chk++;
                if (act != it.exp) begin
                    n_fail++;
                    $display("FAIL %s sel=%0d actual=%0d expected=%0d", it.tag, it.sel, act, it.exp);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) nxt();
        rst_n = 1'b1;
        push(0, 0, "R1 count"); push(1, 0, "R1 flag"); push(2, 1, "R1 irq_n");
        nxt();

        wr_limit_en = 1; wr_data = 8'd3; nxt(); wr_limit_en = 0;   // R11 limit 3

        alarm_n = 0; tick_en = 1; nxt();
        push(0, 1, "R2 bit0 on start, tick ignored");
        nxt(); nxt();
        tick_en = 0;
        push(0, 3, "R3 ticks add"); push(1, 0, "R3 flag");
        alarm_n = 1; tick_en = 1; nxt();
        push(1, 0, "R7 equal does not set");
        nxt(); nxt();
        push(0, 3, "R4 idle ticks ignored");

        tick_en = 0; alarm_n = 0; nxt();
        push(0, 3, "R4 second start keeps total");
        tick_en = 1; nxt(); tick_en = 0;
        push(0, 4, "R4 total grows"); push(1, 0, "R7 flag not yet");
        nxt();
        push(1, 1, "R7 above limit sets"); push(2, 0, "R10 irq low");

        rd_en = 1; push(0, 4, "R5 read data");
        nxt(); rd_en = 0;
        push(0, 1, "R6 read during assertion"); push(1, 1, "R8 sticky after read");

        wr_ctrl_en = 1; wr_data = 8'h01; nxt(); wr_ctrl_en = 0;
        push(2, 1, "R10 mask releases irq"); push(1, 1, "R10 flag kept");

        alarm_n = 1; nxt();
        rd_en = 1; nxt(); rd_en = 0;
        push(0, 0, "R5 read clears idle");

        wr_ctrl_en = 1; wr_data = 8'h02; nxt(); wr_ctrl_en = 0;
        push(1, 0, "R9 clear"); push(2, 1, "R9 irq released");
        nxt();
        push(1, 0, "R9 stays clear");

        wr_limit_en = 1; wr_data = 8'd0; nxt(); wr_limit_en = 0;
        alarm_n = 0; nxt();
        push(0, 1, "R11 count 1"); push(1, 0, "R11 flag pending");
        nxt();
        push(1, 1, "R11 R7 zero limit fires"); push(2, 0, "R10 irq low");

        wr_ctrl_en = 1; wr_data = 8'h02; nxt(); wr_ctrl_en = 0;
        push(1, 0, "R9 clear while above"); push(2, 1, "R9 irq up");
        nxt();
        push(1, 1, "R9 re-set next cycle"); push(2, 0, "R9 irq low again");

        wr_limit_en = 1; wr_data = 8'hFF; nxt(); wr_limit_en = 0;
        tick_en = 1;
        repeat (300) nxt();
        push(0, 255, "R3 saturates");
        wr_ctrl_en = 1; wr_data = 8'h02; nxt(); wr_ctrl_en = 0;
        nxt();
        push(1, 0, "R7 max equal to limit"); push(0, 255, "R3 still max");
        push(2, 1, "R10 irq high");

        alarm_n = 1; tick_en = 0; nxt();
        rd_en = 1; push(0, 255, "R5 read max");
        nxt(); rd_en = 0;
        push(0, 0, "R5 cleared");

        nxt(); nxt();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule